// File: doc/BRIEF.md
# Configurable DRAM Row Bank Decoder

This block turns a 4-bit page number (address bits 15..12) into a column-strobe enable for one of up to three DRAM rows. Each row holds either small devices that cover a single 4 KiB page or large devices that cover four consecutive pages. The rows are stacked from page 0 upward with no gaps. The page comes either from the processor address or from the video scan address, chosen by a select input.

A static 2-bit configuration input stands in for the row-type plugs. A second 2-bit input gives how many rows are fitted. Besides the strobe enables, the block drives two extra address bits that pick the page within a large-device row, and a RAM-select flag that steers the data-in path toward memory.

The decode is combinational: a source multiplexer, two 2-to-4 predecoders and one match stage per row. All outputs are registered once, so results appear one clock after the inputs.

Top module: `dram_row_decoder`

## Requirements
- R1: When `vid_sel_i` is 1 the decoded page is `vid_page_i`; when it is 0 the page is `cpu_page_i`. The unselected page has no effect on any output.
- R2: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low at a rising edge, the outputs clear to zero: `cas_en_o` 000, `xaddr_o` 00, `ram_sel_o` 0.
- R3: `row_cfg_i` equals the number of leading rows built from large devices: 00 means no large rows, 01 means row 0 only, 10 means rows 0 and 1, 11 means all three. A large row spans 4 pages and a small row spans 1 page. Row 0 starts at page 0 and each further row starts where the previous row ends.
- R4: `cas_en_o[i]` is 1 exactly when the page lies inside row i and i is less than `row_cnt_i`.
- R5: At most one bit of `cas_en_o` is 1 for any input.
- R6: `ram_sel_o` is 1 exactly when the page lies inside some populated row.
- R7: On a hit in a large row, `xaddr_o` equals the page minus that row's first page, which is page bits 1..0. On a hit in a small row, and on a miss, `xaddr_o` is 00.
- R8: With `row_cnt_i` equal to 0 no row is populated, and all outputs stay at zero for every page.
- R9: Any page at or above the end of the last populated row drives `cas_en_o` to 000 and `ram_sel_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_page_i | input | 4 | Page number from the processor address, bits 15..12 |
| vid_page_i | input | 4 | Page number from the video scan address, bits 15..12 |
| vid_sel_i | input | 1 | 1 selects the video page, 0 selects the processor page |
| row_cfg_i | input | 2 | Number of leading rows built from large devices |
| row_cnt_i | input | 2 | Number of populated rows |
| cas_en_o | output | 3 | Column-strobe enable, one bit per row |
| xaddr_o | output | 2 | Page offset within a large-device row |
| ram_sel_o | output | 1 | Page maps to memory; steers the data-in path |

## Verification
The assertions assume the configuration and row count may change on any cycle. They also assume every input carries a known 0 or 1 value at each sampled edge after reset. The bench keeps to these assumptions: it drives all inputs from time zero and changes them only at falling edges. It sweeps every page for every configuration and row count 0 to 3, from both sources, and always puts a different value on the unselected source. It applies one reset in the middle of the run while a hitting page is present.

// File: rtl/dram_row_pkg.sv
// Package dram_row_pkg
// Shared sizes and row-layout helpers for the DRAM row bank decoder.
// Assumes large rows always precede small rows, so each large row starts
// on a multiple of its own page span.
package dram_row_pkg;

    localparam int PAGE_W = 4;                 // page number width
    localparam int SUB_W  = 2;                 // offset bits inside a large row
    localparam int HI_W   = PAGE_W - SUB_W;    // block index bits
    localparam int NROWS  = 3;                 // number of row slots
    localparam int CFG_W  = 2;                 // configuration width
    localparam int CNT_W  = 2;                 // row count width
    localparam int BIG_SPAN = 1 << SUB_W;      // pages covered by a large row

    // Whether row idx is built from large devices under configuration cfg.
    function automatic logic row_is_big(input int idx, input logic [CFG_W-1:0] cfg);
        return idx < int'(cfg);
    endfunction

    // First page of row idx when rows are packed from page 0.
    function automatic int row_base(input int idx, input logic [CFG_W-1:0] cfg);
        int n_big;
        n_big = (idx < int'(cfg)) ? idx : int'(cfg);
        return n_big * BIG_SPAN + (idx - n_big);
    endfunction

    // Pages mapped in total by the first cnt rows under configuration cfg.
    function automatic int mapped_pages(input logic [CFG_W-1:0] cfg,
                                        input logic [CNT_W-1:0] cnt);
        int total;
        total = 0;
        for (int i = 0; i < NROWS; i++) begin
            if (i < int'(cnt)) begin
                total = total + (row_is_big(i, cfg) ? BIG_SPAN : 1);
            end
        end
        return total;
    endfunction

endpackage

// File: rtl/page_src_mux.sv
// Module page_src_mux
// Picks the page number for decoding from the processor or the video
// scan source. Assumes both sources are stable page numbers of PAGE_W bits.
module page_src_mux #(
    parameter int PAGE_W = dram_row_pkg::PAGE_W
) (
    input  logic [PAGE_W-1:0] cpu_page_i,
    input  logic [PAGE_W-1:0] vid_page_i,
    input  logic              vid_sel_i,
    output logic [PAGE_W-1:0] page_o
);

    // Select the active address source.
    always_comb begin
        page_o = vid_sel_i ? vid_page_i : cpu_page_i;
    end

endmodule

// File: rtl/page_predecode.sv
// Module page_predecode
// Splits the page number into two one-hot fields: the block index (upper
// bits) and the offset within a block (lower bits). Each field gets its
// own binary-to-one-hot decoder, sized from the parameters.
module page_predecode #(
    parameter int PAGE_W = dram_row_pkg::PAGE_W,
    parameter int SUB_W  = dram_row_pkg::SUB_W
) (
    input  logic [PAGE_W-1:0]             page_i,
    output logic [(1<<(PAGE_W-SUB_W))-1:0] hi_dec_o,
    output logic [(1<<SUB_W)-1:0]          lo_dec_o
);

    localparam int HI_W   = PAGE_W - SUB_W;
    localparam int HI_N   = 1 << HI_W;
    localparam int LO_N   = 1 << SUB_W;

    logic [HI_W-1:0]  hi_field;
    logic [SUB_W-1:0] lo_field;

    assign hi_field = page_i[PAGE_W-1:SUB_W];
    assign lo_field = page_i[SUB_W-1:0];

    genvar g;
    generate
        for (g = 0; g < HI_N; g++) begin : g_hi
            // One output line of the block-index decoder.
            always_comb begin
                hi_dec_o[g] = (hi_field == HI_W'(g));
            end
        end
        for (g = 0; g < LO_N; g++) begin : g_lo
            // One output line of the offset decoder.
            always_comb begin
                lo_dec_o[g] = (lo_field == SUB_W'(g));
            end
        end
    endgenerate

endmodule

// File: rtl/row_match.sv
// Module row_match
// Decides whether the current page falls inside row ROW_IDX, from the
// predecoded lines and the row-type configuration. A large row matches on
// its block line alone; a small row also needs its offset line. Assumes
// large rows precede small rows (base of a large row is block aligned).
module row_match #(
    parameter int ROW_IDX = 0,
    parameter int PAGE_W  = dram_row_pkg::PAGE_W,
    parameter int SUB_W   = dram_row_pkg::SUB_W,
    parameter int CFG_W   = dram_row_pkg::CFG_W,
    parameter int CNT_W   = dram_row_pkg::CNT_W
) (
    input  logic [(1<<(PAGE_W-SUB_W))-1:0] hi_dec_i,
    input  logic [(1<<SUB_W)-1:0]          lo_dec_i,
    input  logic [SUB_W-1:0]               page_lo_i,
    input  logic [CFG_W-1:0]               cfg_i,
    input  logic [CNT_W-1:0]               cnt_i,
    output logic                           hit_o,
    output logic [SUB_W-1:0]               sub_o
);

    import dram_row_pkg::*;

    logic [PAGE_W-1:0]        base;
    logic [PAGE_W-SUB_W-1:0]  blk;
    logic [SUB_W-1:0]         off;
    logic                     big;
    logic                     fitted;

    // Locate this row from the configuration.
    always_comb begin
        base   = PAGE_W'(row_base(ROW_IDX, cfg_i));
        blk    = base[PAGE_W-1:SUB_W];
        off    = base[SUB_W-1:0];
        big    = row_is_big(ROW_IDX, cfg_i);
        fitted = (ROW_IDX < int'(cnt_i));
    end

    // Combine the predecoded lines into the row hit and the offset bits.
    always_comb begin
        hit_o = fitted && hi_dec_i[blk] && (big || lo_dec_i[off]);
        sub_o = (hit_o && big) ? page_lo_i : '0;
    end

endmodule

// File: rtl/dram_row_decoder.sv
// Module dram_row_decoder
// Top of the DRAM row bank decoder. Selects the page source, predecodes
// it, matches it against each row slot and registers the strobe enables,
// the in-row offset bits and the RAM-select flag. Assumes row_cfg_i and
// row_cnt_i are static during normal use; any change takes effect on the
// next clock like any other input.
module dram_row_decoder #(
    parameter int PAGE_W = dram_row_pkg::PAGE_W,
    parameter int SUB_W  = dram_row_pkg::SUB_W,
    parameter int NROWS  = dram_row_pkg::NROWS,
    parameter int CFG_W  = dram_row_pkg::CFG_W,
    parameter int CNT_W  = dram_row_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] cpu_page_i,
    input  logic [PAGE_W-1:0] vid_page_i,
    input  logic              vid_sel_i,
    input  logic [CFG_W-1:0]  row_cfg_i,
    input  logic [CNT_W-1:0]  row_cnt_i,
    output logic [NROWS-1:0]  cas_en_o,
    output logic [SUB_W-1:0]  xaddr_o,
    output logic              ram_sel_o
);

    import dram_row_pkg::*;

    localparam int HI_N = 1 << (PAGE_W - SUB_W);
    localparam int LO_N = 1 << SUB_W;

    logic [PAGE_W-1:0] page;
    logic [HI_N-1:0]   hi_dec;
    logic [LO_N-1:0]   lo_dec;
    logic [NROWS-1:0]  row_hit;
    logic [SUB_W-1:0]  row_sub [NROWS];
    logic [SUB_W-1:0]  sub_nxt;

    page_src_mux #(.PAGE_W(PAGE_W)) u_mux (
        .cpu_page_i (cpu_page_i),
        .vid_page_i (vid_page_i),
        .vid_sel_i  (vid_sel_i),
        .page_o     (page)
    );

    page_predecode #(.PAGE_W(PAGE_W), .SUB_W(SUB_W)) u_predec (
        .page_i   (page),
        .hi_dec_o (hi_dec),
        .lo_dec_o (lo_dec)
    );

    genvar r;
    generate
        for (r = 0; r < NROWS; r++) begin : g_row
            row_match #(
                .ROW_IDX (r),
                .PAGE_W  (PAGE_W),
                .SUB_W   (SUB_W),
                .CFG_W   (CFG_W),
                .CNT_W   (CNT_W)
            ) u_row (
                .hi_dec_i  (hi_dec),
                .lo_dec_i  (lo_dec),
                .page_lo_i (page[SUB_W-1:0]),
                .cfg_i     (row_cfg_i),
                .cnt_i     (row_cnt_i),
                .hit_o     (row_hit[r]),
                .sub_o     (row_sub[r])
            );
        end
    endgenerate

    // Merge the per-row offsets; only a hitting large row drives non-zero.
    always_comb begin
        sub_nxt = '0;
        for (int i = 0; i < NROWS; i++) begin
            sub_nxt = sub_nxt | row_sub[i];
        end
    end

    // Register all outputs, clearing them on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_en_o  <= '0;
            xaddr_o   <= '0;
            ram_sel_o <= 1'b0;
        end else begin
            cas_en_o  <= row_hit;
            xaddr_o   <= sub_nxt;
            ram_sel_o <= |row_hit;
        end
    end

    // ---------------- assertions ----------------
    int unsigned span_now;
    assign span_now = unsigned'(mapped_pages(row_cfg_i, row_cnt_i));

    // R2: a reset edge leaves every output cleared.
    a_r2_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cas_en_o == '0 && xaddr_o == '0 && !ram_sel_o));

    // R5: never more than one row strobed.
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cas_en_o));

    // R6: RAM-select agrees with the strobe enables.
    a_r6_sel_tracks_rows: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel_o == (cas_en_o != '0));

    // R6: a page inside the mapped span selects memory next cycle.
    a_r6_inside_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(page) < int'(span_now)) |=> ram_sel_o);

    // R9: a page past the mapped span selects nothing next cycle.
    a_r9_beyond_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(page) >= int'(span_now)) |=> (!ram_sel_o && cas_en_o == '0));

    // R7: offset bits are zero whenever no row is selected.
    a_r7_offset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_o |-> (xaddr_o == '0));

endmodule

// File: tb/test_dram_row_decoder.sv
`timescale 1ns/1ps
module test_dram_row_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_page = 4'd0;
    logic [3:0] vid_page = 4'd0;
    logic       vid_sel = 1'b0;
    logic [1:0] row_cfg = 2'd3;
    logic [1:0] row_cnt = 2'd3;
    logic [2:0] cas_en;
    logic [1:0] xaddr;
    logic       ram_sel;

    always #2.5 clk = ~clk;   // 200 MHz

    dram_row_decoder i_dram_row_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_page_i (cpu_page),
        .vid_page_i (vid_page),
        .vid_sel_i  (vid_sel),
        .row_cfg_i  (row_cfg),
        .row_cnt_i  (row_cnt),
        .cas_en_o   (cas_en),
        .xaddr_o    (xaddr),
        .ram_sel_o  (ram_sel)
    );

    typedef struct {
        logic [2:0] cas;
        logic [1:0] xa;
        logic       sel;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done   = 0;

    // Reference model from R3, R4, R6, R7, R8, R9.
    function automatic exp_t model(input int page, input int cfg, input int cnt);
        exp_t e;
        int   base;
        e.cas = '0; e.xa = '0; e.sel = 1'b0; e.tag = "R4";
        base = 0;
        for (int i = 0; i < 3; i++) begin
            int size;
            size = (i < cfg) ? 4 : 1;
            if (i < cnt && page >= base && page < base + size) begin
                e.cas[i] = 1'b1;
                e.sel    = 1'b1;
                if (size == 4) e.xa = 2'(page - base);
            end
            if (i < cnt) base = base + size;
        end
        if (cnt == 0)          e.tag = "R8";
        else if (page >= base) e.tag = "R9";
        return e;
    endfunction

    // Driver: apply one vector at a falling edge and queue its expectation.
    task automatic apply(input int page, input int cfg, input int cnt,
                         input bit vsel, input bit rst);
        exp_t e;
        @(negedge clk);
        vid_sel  = vsel;
        cpu_page = vsel ? 4'(~page) : 4'(page);
        vid_page = vsel ? 4'(page) : 4'(~page);
        row_cfg  = 2'(cfg);
        row_cnt  = 2'(cnt);
        rst_n    = ~rst;
        if (rst) begin
            e.cas = '0; e.xa = '0; e.sel = 1'b0; e.tag = "R2";
        end else begin
            e = model(page, cfg, cnt);
            if (vsel && e.tag == "R4") e.tag = "R1";
        end
        sb_q.push_back(e);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pop and compare just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, {1'b0, cas_en}, {1'b0, e.cas});
            check((e.tag == "R2") ? "R2" : "R6", {3'b0, ram_sel}, {3'b0, e.sel});
            check((e.tag == "R2") ? "R2" : "R7", {2'b0, xaddr}, {2'b0, e.xa});
            check("R5", {3'b0, $countones(cas_en) > 1}, 4'd0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R2: reset state, queued before the first edge.
        exp_t e0;
        e0.cas = '0; e0.xa = '0; e0.sel = 1'b0; e0.tag = "R2";
        sb_q.push_back(e0);
        apply(0, 3, 3, 0, 1);
        // R3 sweep: every configuration, row count, page and source.
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int cnt = 0; cnt < 4; cnt++) begin
                for (int vs = 0; vs < 2; vs++) begin
                    for (int pg = 0; pg < 16; pg++) begin
                        apply(pg, cfg, cnt, vs[0], 0);
                    end
                end
            end
        end
        // R2: reset mid-run with a hitting page present, then recovery.
        apply(5, 3, 3, 0, 1);
        apply(5, 3, 3, 0, 0);
        apply(9, 2, 3, 1, 0);
        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule